// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel keeps a 16-bit count, which software sees as two byte registers, one low and one high. One shared mode byte picks, per channel, the counting structure, whether increments come from the internal tick or from an external count pin, and whether an external gate pin qualifies counting. One control byte holds each channel's run bit and overflow flag. The flags also drive the block's outputs, so an interrupt controller can sample them and return an acknowledge pulse.

There are four counting structures. The first is a 13-bit counter whose low five bits live in the low byte. The second is a full 16-bit counter. The third is an 8-bit counter that reloads from the high byte. The fourth is a split arrangement: channel 0 becomes two independent 8-bit counters, and channel 1 is frozen when it selects this structure itself. Software reaches everything through a byte-wide register port with a write strobe and a combinational read.

Top module: `dual_tmr`

## Requirements
- R1: After reset, all four count bytes, the mode byte, the run bits and the overflow flags are zero, and `ovf_o` is 2'b00.
- R2: Register addresses are: 0 = channel 0 low, 1 = channel 0 high, 2 = channel 1 low, 3 = channel 1 high, 4 = mode, 5 = control. A written value reads back unchanged. Control bits 3..0 read as zero. Control bit 7 is the channel 1 flag, bit 6 the channel 1 run bit, bit 5 the channel 0 flag and bit 4 the channel 0 run bit.
- R3: Mode byte: channel 0 uses bits 3..0 and channel 1 uses bits 7..4. In each nibble, bit 3 is gate, bit 2 is source (1 = external pin) and bits 1..0 are the structure. Structure 1 increments {high,low} as a 16-bit value and overflows from FFFF to 0000.
- R4: Structure 0 increments the 13-bit value {high, low[4:0]}. It overflows from all ones to zero, and low[7:5] keep their written value.
- R5: Structure 2 increments the low byte only. When the low byte steps from FF, it is loaded with the high byte instead, and this sets the channel flag.
- R6: When channel 0 selects structure 3, its low byte counts with channel 0's run bit, gate and source and sets flag 0. Its high byte counts internal ticks under channel 1's run bit alone and sets flag 1. In this state an overflow of channel 1 does not set flag 1.
- R7: When channel 1 selects structure 3, channel 1's count bytes do not change except by software writes.
- R8: With source = 1, the external count pin passes through a two-stage synchroniser, and each falling edge is held until the next internal tick. The channel then advances by at most one per tick, however many edges arrived. No count of any kind advances in a cycle without a tick.
- R9: With gate = 1, a running channel counts only while its synchronised gate pin is high. With gate = 0, the run bit alone enables it.
- R10: An overflow sets the channel flag, and a pulse on `irq_ack_i[c]` clears flag c. A hardware set wins over an acknowledge in the same cycle, and `ovf_o[c]` shows flag c.
- R11: A control write stores bits 7 and 5 into the flags even when a hardware overflow occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| tick_i | input | 1 | Internal count-enable tick |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | External gate pins, one per channel |
| irq_ack_i | input | 2 | Overflow acknowledge pulses, one per channel |
| ovf_o | output | 2 | Overflow flags, one per channel |

## Verification
Any wrong count state shows up on the next read of the count bytes. It also shows one overflow later as a flag that rises at the wrong tick, so every sequence checks both the final count and the flag state. Split-mode errors are the subtle ones: a wrong run-bit or flag routing leaves the count bytes plausible but moves a flag into the wrong channel. Those cases are therefore checked one tick after the first wrap. A missed external edge or a doubled one is visible after a single tick, three synchroniser cycles after the pin falls.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [1:0] {
      MD_PRESCALE13 = 2'd0,
      MD_CASCADE16  = 2'd1,
      MD_RELOAD8    = 2'd2,
      MD_SPLIT      = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      ext_src;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam logic [2:0] ADR_LO0  = 3'd0;
   localparam logic [2:0] ADR_HI0  = 3'd1;
   localparam logic [2:0] ADR_LO1  = 3'd2;
   localparam logic [2:0] ADR_HI1  = 3'd3;
   localparam logic [2:0] ADR_MODE = 3'd4;
   localparam logic [2:0] ADR_CTRL = 3'd5;
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tmr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-2:0], pin_i};
   end

   assign lvl_o = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_edge_catch.sv
`timescale 1ns/1ps
module tmr_edge_catch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic tick_i,
   output logic evt_o
);
   logic last_q, pend_q, fall;

   assign fall  = last_q & ~lvl_i;
   assign evt_o = tick_i & (pend_q | fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         last_q <= lvl_i;
         pend_q <= tick_i ? 1'b0 : (pend_q | fall);
      end
   end

   // R8: an edge seen without a tick stays held until a tick takes it
   AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !tick_i) |=> pend_q); // R8
endmodule

// File: rtl/tmr_count_unit.sv
`timescale 1ns/1ps
module tmr_count_unit
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  tmr_mode_e          mode_i,
   input  logic [BYTE_W-1:0]  lo_i,
   input  logic [BYTE_W-1:0]  hi_i,
   input  logic               inc_lo_i,
   input  logic               inc_hi_i,
   output logic [BYTE_W-1:0]  lo_o,
   output logic [BYTE_W-1:0]  hi_o,
   output logic               ovf_main_o,
   output logic               ovf_hi_o
);
   localparam int PW = BYTE_W + PRE_W;
   localparam int FW = 2 * BYTE_W;

   logic [PW-1:0] pre_cur, pre_inc;
   logic [FW-1:0] full_inc;

   assign pre_cur  = {hi_i, lo_i[PRE_W-1:0]};
   assign pre_inc  = pre_cur + 1'b1;
   assign full_inc = {hi_i, lo_i} + 1'b1;

   always_comb begin
      lo_o       = lo_i;
      hi_o       = hi_i;
      ovf_main_o = 1'b0;
      ovf_hi_o   = 1'b0;
      unique case (mode_i)
         MD_PRESCALE13: if (inc_lo_i) begin
            hi_o       = pre_inc[PW-1:PRE_W];
            lo_o       = {lo_i[BYTE_W-1:PRE_W], pre_inc[PRE_W-1:0]};
            ovf_main_o = &pre_cur;
         end
         MD_CASCADE16: if (inc_lo_i) begin
            {hi_o, lo_o} = full_inc;
            ovf_main_o   = &{hi_i, lo_i};
         end
         MD_RELOAD8: if (inc_lo_i) begin
            lo_o       = (&lo_i) ? hi_i : lo_i + 1'b1;
            ovf_main_o = &lo_i;
         end
         MD_SPLIT: begin
            if (inc_lo_i) begin
               lo_o       = lo_i + 1'b1;
               ovf_main_o = &lo_i;
            end
            if (inc_hi_i) begin
               hi_o     = hi_i + 1'b1;
               ovf_hi_o = &hi_i;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dual_tmr.sv
`timescale 1ns/1ps
module dual_tmr
   import tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              tick_i,
   input  logic [1:0]        cnt_pin_i,
   input  logic [1:0]        gate_pin_i,
   input  logic [1:0]        irq_ack_i,
   output logic [1:0]        ovf_o
);
   localparam int NCH = 2;

   generate
      if (BYTE_W < 8) begin : g_bad_w
         $error("dual_tmr: BYTE_W must be at least 8");
      end
      if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
         $error("dual_tmr: PRE_W must lie in 1..BYTE_W-1");
      end
   endgenerate

   logic [BYTE_W-1:0] lo_q [NCH];
   logic [BYTE_W-1:0] hi_q [NCH];
   logic [BYTE_W-1:0] lo_nxt [NCH];
   logic [BYTE_W-1:0] hi_nxt [NCH];
   logic [7:0]        mode_q;
   logic [NCH-1:0]    run_q, flag_q, flag_set;
   logic [NCH-1:0]    inc_lo, inc_hi, ovf_main, ovf_hi;
   logic              split0, wr_ctrl;

   assign split0  = (mode_q[1:0] == MD_SPLIT);
   assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      tmr_cfg_t cfg;
      logic     gate_lvl, cnt_lvl, ext_evt, src, enable;

      assign cfg = tmr_cfg_t'(mode_q[4*c +: 4]);

      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
         .clk(clk), .rst_n(rst_n), .pin_i(gate_pin_i[c]), .lvl_o(gate_lvl));
      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
         .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i[c]), .lvl_o(cnt_lvl));
      tmr_edge_catch u_edge (
         .clk(clk), .rst_n(rst_n), .lvl_i(cnt_lvl), .tick_i(tick_i), .evt_o(ext_evt));

      assign src    = cfg.ext_src ? ext_evt : tick_i;
      assign enable = run_q[c] & (~cfg.gate | gate_lvl);

      if (c == 0) begin : g_splittable
         assign inc_lo[c] = enable & src;
         assign inc_hi[c] = split0 & run_q[1] & tick_i;
      end else begin : g_follower
         assign inc_lo[c] = (cfg.mode != MD_SPLIT) & enable & src;
         assign inc_hi[c] = 1'b0;
      end

      tmr_count_unit #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_count (
         .mode_i(cfg.mode), .lo_i(lo_q[c]), .hi_i(hi_q[c]),
         .inc_lo_i(inc_lo[c]), .inc_hi_i(inc_hi[c]),
         .lo_o(lo_nxt[c]), .hi_o(hi_nxt[c]),
         .ovf_main_o(ovf_main[c]), .ovf_hi_o(ovf_hi[c]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[c] <= '0;
            hi_q[c] <= '0;
         end else begin
            lo_q[c] <= (bus_wr && bus_addr == 3'(2*c))     ? bus_wdata : lo_nxt[c];
            hi_q[c] <= (bus_wr && bus_addr == 3'(2*c + 1)) ? bus_wdata : hi_nxt[c];
         end
      end
   end

   assign flag_set[0] = ovf_main[0];
   assign flag_set[1] = ovf_hi[0] | ovf_hi[1] | (ovf_main[1] & ~split0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         run_q  <= '0;
         flag_q <= '0;
      end else begin
         if (bus_wr && bus_addr == ADR_MODE) mode_q <= bus_wdata[7:0];
         if (wr_ctrl) begin
            run_q  <= {bus_wdata[6], bus_wdata[4]};
            flag_q <= {bus_wdata[7], bus_wdata[5]};
         end else begin
            flag_q <= (flag_q & ~irq_ack_i) | flag_set;
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         ADR_LO0:  bus_rdata = lo_q[0];
         ADR_HI0:  bus_rdata = hi_q[0];
         ADR_LO1:  bus_rdata = lo_q[1];
         ADR_HI1:  bus_rdata = hi_q[1];
         ADR_MODE: bus_rdata = BYTE_W'(mode_q);
         ADR_CTRL: bus_rdata = BYTE_W'({flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000});
         default:  bus_rdata = '0;
      endcase
   end

   assign ovf_o = flag_q;

   AST_FLAG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_set != '0) && !wr_ctrl) |=> ((flag_q & $past(flag_set)) == $past(flag_set))); // R10
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctrl && irq_ack_i[0] && !flag_set[0]) |=> !ovf_o[0]); // R10
   AST_SW_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ovf_o == {$past(bus_wdata[7]), $past(bus_wdata[5])})); // R11
   AST_CH1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[5:4] == 2'b11) && !(bus_wr && (bus_addr == ADR_LO1 || bus_addr == ADR_HI1)))
      |=> ($stable(lo_q[1]) && $stable(hi_q[1]))); // R7
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !bus_wr) |=> ($stable(lo_q[0]) && $stable(hi_q[0])
                                && $stable(lo_q[1]) && $stable(hi_q[1]))); // R8
endmodule

// File: tb/test_dual_tmr.sv
`timescale 1ns/1ps
module test_dual_tmr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tick_i = 1'b0;
   logic [1:0] cnt_pin_i = 2'b11;
   logic [1:0] gate_pin_i = 2'b00;
   logic [1:0] irq_ack_i = 2'b00;
   logic [1:0] ovf_o;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   dual_tmr i_dual_tmr (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
      .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i), .irq_ack_i(irq_ack_i),
      .ovf_o(ovf_o));

   typedef struct packed {
      logic       ch;
      logic [7:0] mode;
      logic [7:0] lo;
      logic [7:0] hi;
      logic [7:0] n;
      logic [7:0] exp_lo;
      logic [7:0] exp_hi;
      logic       exp_flag;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h01, 8'hFE, 8'h00, 8'd3, 8'h01, 8'h01, 1'b0},  // R3 carry into high
      '{1'b0, 8'h01, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1},  // R3 wrap
      '{1'b0, 8'h00, 8'h1E, 8'h05, 8'd3, 8'h01, 8'h06, 1'b0},  // R4 prescaler carry
      '{1'b0, 8'h00, 8'hFF, 8'hFF, 8'd2, 8'hE1, 8'h00, 1'b1},  // R4 wrap, upper bits kept
      '{1'b0, 8'h02, 8'hFD, 8'h80, 8'd5, 8'h82, 8'h80, 1'b1},  // R5 reload
      '{1'b0, 8'h02, 8'h10, 8'h33, 8'd4, 8'h14, 8'h33, 1'b0},  // R5 no reload
      '{1'b1, 8'h10, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},  // R3 channel 1
      '{1'b1, 8'h30, 8'h10, 8'h22, 8'd5, 8'h10, 8'h22, 1'b0}   // R7 frozen
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic fall_pulse();
      @(negedge clk); cnt_pin_i[0] = 1'b0;
      repeat (2) @(negedge clk);
      cnt_pin_i[0] = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d, d2, d3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         chk("R1 reset register", {8'h00, d}, 16'h0000);
      end
      chk("R1 reset flags", {14'h0, ovf_o}, 16'h0000);

      // R2 register access
      wr(3'd2, 8'h5A); wr(3'd3, 8'hA5); wr(3'd4, 8'h96);
      rd(3'd2, d); chk("R2 low1 readback", {8'h00, d}, 16'h005A);
      rd(3'd3, d); chk("R2 high1 readback", {8'h00, d}, 16'h00A5);
      rd(3'd4, d); chk("R2 mode readback", {8'h00, d}, 16'h0096);
      wr(3'd5, 8'hFF);
      rd(3'd5, d); chk("R2 control unused bits", {8'h00, d}, 16'h00F0);
      wr(3'd5, 8'h00); wr(3'd4, 8'h00);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [2:0] base;
         base = VEC[i].ch ? 3'd2 : 3'd0;
         wr(3'd5, 8'h00);
         wr(3'd4, VEC[i].mode);
         wr(base, VEC[i].lo);
         wr(base + 3'd1, VEC[i].hi);
         wr(3'd5, VEC[i].ch ? 8'h40 : 8'h10);
         ticks(int'(VEC[i].n));
         chk("R10 vector flag", {15'h0, ovf_o[VEC[i].ch]}, {15'h0, VEC[i].exp_flag});
         rd(base, d); rd(base + 3'd1, d2);
         chk("R3/R4/R5/R7 vector count", {d2, d}, {VEC[i].exp_hi, VEC[i].exp_lo});
      end
      wr(3'd5, 8'h00);

      // R6 split mode: both halves run
      wr(3'd4, 8'h13);
      wr(3'd0, 8'hFE); wr(3'd1, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      wr(3'd5, 8'h50);
      ticks(2);
      rd(3'd0, d); rd(3'd1, d2);
      chk("R6 split counts", {d2, d}, 16'h0100);
      rd(3'd2, d); chk("R6 channel 1 still counts", {8'h00, d}, 16'h0002);
      chk("R6 both flags", {14'h0, ovf_o}, 16'h0003);
      // R6 high half under channel 1 run only; channel 1 wrap must not set flag 1
      wr(3'd5, 8'h00);
      wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      wr(3'd5, 8'h40);
      ticks(1);
      rd(3'd0, d); rd(3'd1, d2);
      chk("R6 high half only", {d2, d}, 16'h0100);
      rd(3'd2, d); rd(3'd3, d2);
      chk("R6 channel 1 wrapped", {d2, d}, 16'h0000);
      chk("R6 channel 1 overflow ignored", {14'h0, ovf_o}, 16'h0000);
      wr(3'd5, 8'h10);
      ticks(1);
      rd(3'd0, d); rd(3'd1, d2);
      chk("R6 low half only", {d2, d}, 16'h0101);
      wr(3'd5, 8'h00);

      // R9 gating
      wr(3'd4, 8'h09); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
      wr(3'd5, 8'h10);
      ticks(4);
      rd(3'd0, d); chk("R9 gate low blocks", {8'h00, d}, 16'h0000);
      gate_pin_i[0] = 1'b1;
      repeat (4) @(negedge clk);
      ticks(4);
      rd(3'd0, d); chk("R9 gate high counts", {8'h00, d}, 16'h0004);
      gate_pin_i[0] = 1'b0;
      wr(3'd5, 8'h00);

      // R8 external count source
      wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
      wr(3'd5, 8'h10);
      @(negedge clk); tick_i = 1'b1;
      repeat (3) fall_pulse();
      repeat (6) @(negedge clk);
      tick_i = 1'b0;
      rd(3'd0, d); chk("R8 one count per edge", {8'h00, d}, 16'h0003);
      repeat (3) fall_pulse();
      repeat (4) @(negedge clk);
      rd(3'd0, d); chk("R8 no tick no count", {8'h00, d}, 16'h0003);
      ticks(1);
      rd(3'd0, d); chk("R8 at most one per tick", {8'h00, d}, 16'h0004);
      ticks(1);
      rd(3'd0, d3); chk("R8 pending consumed", {8'h00, d3}, 16'h0004);
      wr(3'd5, 8'h00);

      // R11 software write beats hardware set
      wr(3'd4, 8'h01); wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
      wr(3'd5, 8'h10);
      @(negedge clk);
      tick_i = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h10;
      @(negedge clk);
      tick_i = 1'b0; bus_wr = 1'b0;
      chk("R11 write wins over overflow", {14'h0, ovf_o}, 16'h0000);
      rd(3'd0, d); rd(3'd1, d2);
      chk("R11 count still wrapped", {d2, d}, 16'h0000);

      // R10 acknowledge
      wr(3'd5, 8'hA0);
      chk("R11 software sets flags", {14'h0, ovf_o}, 16'h0003);
      @(negedge clk); irq_ack_i = 2'b10;
      @(negedge clk); irq_ack_i = 2'b00;
      chk("R10 ack clears flag 1", {14'h0, ovf_o}, 16'h0001);
      @(negedge clk); irq_ack_i = 2'b01;
      @(negedge clk); irq_ack_i = 2'b00;
      chk("R10 ack clears flag 0", {14'h0, ovf_o}, 16'h0000);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule